// File: doc/BRIEF.md
# Fully Associative Victim Buffer

This block is a small fully associative store placed behind a direct-mapped first-level cache. It holds only lines that the first-level cache throws out. Those lines arrive either on the eviction port or as a swap line that comes with a lookup. When the first-level cache misses, it sends the block address to the buffer. Every valid entry is compared in parallel, and the answer appears one cycle later.

On a hit, the buffer hands the stored line and its dirty flag back to the first-level cache. In the same transaction, the line the first-level cache displaces takes over the matching entry. On a miss, nothing changes, and the request carries on to the next memory level.

When every entry is valid, a new eviction overwrites the entry that was written longest ago. If that entry is dirty, its line leaves on the write-back port. The entry count is a parameter from 4 to 16. The tag is the whole block address: 22 bits for a 24-bit byte address with 4-byte lines.

Top module: `victim_buffer`

## Requirements
- R1: While `rst_ni` is low and after it is released, no entry is valid. `resp_valid_o` and `wb_valid_o` stay low, and the first lookup after reset misses.
- R2: A lookup compares its block address against every valid entry, whatever slot holds it. On a hit, `resp_hit_o` is 1, and `resp_line_o` and `resp_dirty_o` carry the stored line and dirty flag.
- R3: `resp_valid_o` is high exactly in the cycle after each cycle with `lookup_valid_i` high, and in no other cycle. On a miss, `resp_hit_o` is 0 and `resp_line_o` is zero.
- R4: On a hit with `swap_valid_i` high, the swap line (address, data, dirty flag) replaces the matching entry. A later lookup of the swap address hits with that data and flag, and a later lookup of the returned address misses.
- R5: On a hit with `swap_valid_i` low, the matching entry is freed, so a later lookup of the same address misses.
- R6: An eviction presented while a free entry exists stores the line without displacing anything and produces no write-back.
- R7: An eviction presented while all entries are valid overwrites the entry whose last write is the oldest. Both evictions and swap-ins count as writes.
- R8: When an overwritten entry is dirty, `wb_valid_o` is high for one cycle, the cycle after the eviction, with that entry's block address and line. Overwriting a clean entry gives no pulse.
- R9: An eviction presented in the same cycle as a lookup is ignored: it stores nothing and displaces nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evict_valid_i | input | 1 | An evicted line is offered |
| evict_blk_i | input | TAG_W | Block address of the evicted line |
| evict_line_i | input | LINE_W | Data of the evicted line |
| evict_dirty_i | input | 1 | Evicted line is modified |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_blk_i | input | TAG_W | Block address searched |
| swap_valid_i | input | 1 | A displaced line accompanies the lookup |
| swap_blk_i | input | TAG_W | Block address of the displaced line |
| swap_line_i | input | LINE_W | Data of the displaced line |
| swap_dirty_i | input | 1 | Displaced line is modified |
| resp_valid_o | output | 1 | Lookup answer valid |
| resp_hit_o | output | 1 | Lookup found the block |
| resp_line_o | output | LINE_W | Returned line on a hit |
| resp_dirty_o | output | 1 | Dirty flag of the returned line |
| wb_valid_o | output | 1 | Dirty line pushed out to the next level |
| wb_blk_o | output | TAG_W | Block address of the pushed-out line |
| wb_line_o | output | LINE_W | Data of the pushed-out line |

## Verification
The bench builds the buffer with four entries, a 24-bit byte address, 2 offset bits and 32-bit lines. At that size the buffer fills after four evictions, so wrap-around replacement, write-backs of dirty lines and the interaction of swap-ins with replacement order all occur within a few dozen cycles. A long randomized phase then works twelve block addresses through the four slots. It mixes back-to-back lookups, swaps, frees, evictions and collisions of an eviction with a lookup, so every slot is replaced many times in many different age orders.

// File: rtl/vb_pkg.sv
package vb_pkg;
  localparam int unsigned VB_MIN_ENTRIES = 4;
  localparam int unsigned VB_MAX_ENTRIES = 16;

  typedef enum logic [1:0] {
    VB_IDLE,
    VB_EVICT,
    VB_LOOKUP
  } vb_op_e;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned TAG_W   = 22,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]              key_i,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              idx_o
);
  logic [ENTRIES-1:0] hit_vec;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit_vec[e] = valid_i[e] && (tag_i[e] == key_i);
  end

  // at most one entry matches in legal use; lowest index wins otherwise
  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/vb_age.sv
module vb_age #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] oldest_o
);
  // older_q[i][j]: entry i was written before entry j
  logic [ENTRIES-1:0] older_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) begin
        for (int j = 0; j < ENTRIES; j++) begin
          older_q[i][j] <= (i < j);
        end
      end
    end else if (touch_i) begin
      for (int j = 0; j < ENTRIES; j++) begin
        if (IDX_W'(j) != touch_idx_i) begin
          older_q[touch_idx_i][j] <= 1'b0;
          older_q[j][touch_idx_i] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    oldest_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      logic all_older;
      all_older = 1'b1;
      for (int j = 0; j < ENTRIES; j++) begin
        if (i != j) all_older = all_older & older_q[i][j];
      end
      if (all_older) oldest_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vb_alloc.sv
module vb_alloc #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [IDX_W-1:0]   oldest_i,
  output logic               full_o,
  output logic [IDX_W-1:0]   slot_o
);
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign full_o = &valid_i;
  assign slot_o = full_o ? oldest_i : free_idx;
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
  import vb_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned OFFS_W  = 2,
  parameter int unsigned LINE_W  = 32,
  localparam int unsigned TAG_W  = ADDR_W - OFFS_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evict_valid_i,
  input  logic [TAG_W-1:0]  evict_blk_i,
  input  logic [LINE_W-1:0] evict_line_i,
  input  logic              evict_dirty_i,
  input  logic              lookup_valid_i,
  input  logic [TAG_W-1:0]  lookup_blk_i,
  input  logic              swap_valid_i,
  input  logic [TAG_W-1:0]  swap_blk_i,
  input  logic [LINE_W-1:0] swap_line_i,
  input  logic              swap_dirty_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [LINE_W-1:0] resp_line_o,
  output logic              resp_dirty_o,
  output logic              wb_valid_o,
  output logic [TAG_W-1:0]  wb_blk_o,
  output logic [LINE_W-1:0] wb_line_o
);
  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0]            dirty_q;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
  logic [LINE_W-1:0]             line_q [ENTRIES];

  vb_op_e           op;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] oldest_idx;
  logic [IDX_W-1:0] slot_idx;
  logic             full;

  logic              wr_en;
  logic              clr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  logic [LINE_W-1:0] wr_line;
  logic              wr_dirty;
  logic              wb_fire;

  // lookup has priority; a colliding eviction is dropped
  assign op = lookup_valid_i ? VB_LOOKUP : (evict_valid_i ? VB_EVICT : VB_IDLE);

  vb_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) match_i (
    .valid_i (valid_q),
    .tag_i   (tag_q),
    .key_i   (lookup_blk_i),
    .hit_o   (hit),
    .idx_o   (hit_idx)
  );

  vb_age #(.ENTRIES(ENTRIES)) age_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (wr_en),
    .touch_idx_i (wr_idx),
    .oldest_o    (oldest_idx)
  );

  vb_alloc #(.ENTRIES(ENTRIES)) alloc_i (
    .valid_i  (valid_q),
    .oldest_i (oldest_idx),
    .full_o   (full),
    .slot_o   (slot_idx)
  );

  always_comb begin
    wr_en    = 1'b0;
    clr_en   = 1'b0;
    wr_idx   = slot_idx;
    wr_tag   = evict_blk_i;
    wr_line  = evict_line_i;
    wr_dirty = evict_dirty_i;
    unique case (op)
      VB_LOOKUP: begin
        wr_idx   = hit_idx;
        wr_tag   = swap_blk_i;
        wr_line  = swap_line_i;
        wr_dirty = swap_dirty_i;
        if (hit) begin
          wr_en  = swap_valid_i;
          clr_en = !swap_valid_i;
        end
      end
      VB_EVICT: wr_en = 1'b1;
      default: ;
    endcase
  end

  assign wb_fire = (op == VB_EVICT) && full && dirty_q[slot_idx];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic v_q, d_q;
    logic sel;
    assign sel = (wr_idx == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (wr_en && sel) begin
        v_q <= 1'b1;
        d_q <= wr_dirty;
      end else if (clr_en && sel) begin
        v_q <= 1'b0;
      end
    end

    always_ff @(posedge clk_i) begin
      if (wr_en && sel) begin
        tag_q[e]  <= wr_tag;
        line_q[e] <= wr_line;
      end
    end

    assign valid_q[e] = v_q;
    assign dirty_q[e] = d_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_line_o  <= '0;
      resp_dirty_o <= 1'b0;
      wb_valid_o   <= 1'b0;
    end else begin
      resp_valid_o <= (op == VB_LOOKUP);
      resp_hit_o   <= (op == VB_LOOKUP) && hit;
      resp_line_o  <= ((op == VB_LOOKUP) && hit) ? line_q[hit_idx] : '0;
      resp_dirty_o <= (op == VB_LOOKUP) && hit && dirty_q[hit_idx];
      wb_valid_o   <= wb_fire;
    end
  end

  // old contents captured at the same edge that overwrites the slot
  always_ff @(posedge clk_i) begin
    if (wb_fire) begin
      wb_blk_o  <= tag_q[slot_idx];
      wb_line_o <= line_q[slot_idx];
    end
  end
endmodule

// File: rtl/vb_chk.sv
module vb_chk #(
  parameter int unsigned ENTRIES = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lookup_valid_i,
  input logic               evict_valid_i,
  input logic               swap_valid_i,
  input logic               resp_valid_o,
  input logic               resp_hit_o,
  input logic               wb_valid_o,
  input logic [ENTRIES-1:0] valid_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (valid_q == '0));

  // R3
  resp_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> resp_valid_o);

  // R3
  resp_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(lookup_valid_i));

  // R2
  hit_in_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_hit_o |-> resp_valid_o);

  // R5
  free_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_hit_o && $past(!swap_valid_i)) |->
      ($countones(valid_q) + 1 == $past($countones(valid_q))));

  // R6
  fill_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evict_valid_i && !lookup_valid_i && !(&valid_q)) |=>
      (!wb_valid_o && ($countones(valid_q) == $past($countones(valid_q)) + 1)));

  // R8
  wb_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> $past(evict_valid_i && !lookup_valid_i && (&valid_q)));

  // R9
  collide_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_valid_i && evict_valid_i) |=> !wb_valid_o);
endmodule

bind victim_buffer vb_chk #(.ENTRIES(ENTRIES)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lookup_valid_i (lookup_valid_i),
  .evict_valid_i  (evict_valid_i),
  .swap_valid_i   (swap_valid_i),
  .resp_valid_o   (resp_valid_o),
  .resp_hit_o     (resp_hit_o),
  .wb_valid_o     (wb_valid_o),
  .valid_q        (valid_q)
);

// File: tb/victim_buffer_tb_top.sv
module victim_buffer_tb_top;
  localparam int N  = 4;
  localparam int TW = 22;
  localparam int LW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_ni;
  logic          evict_valid_i, evict_dirty_i;
  logic [TW-1:0] evict_blk_i;
  logic [LW-1:0] evict_line_i;
  logic          lookup_valid_i, swap_valid_i, swap_dirty_i;
  logic [TW-1:0] lookup_blk_i, swap_blk_i;
  logic [LW-1:0] swap_line_i;
  logic          resp_valid_o, resp_hit_o, resp_dirty_o, wb_valid_o;
  logic [LW-1:0] resp_line_o, wb_line_o;
  logic [TW-1:0] wb_blk_o;

  victim_buffer #(.ENTRIES(N), .ADDR_W(24), .OFFS_W(2), .LINE_W(LW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .evict_valid_i(evict_valid_i), .evict_blk_i(evict_blk_i),
    .evict_line_i(evict_line_i), .evict_dirty_i(evict_dirty_i),
    .lookup_valid_i(lookup_valid_i), .lookup_blk_i(lookup_blk_i),
    .swap_valid_i(swap_valid_i), .swap_blk_i(swap_blk_i),
    .swap_line_i(swap_line_i), .swap_dirty_i(swap_dirty_i),
    .resp_valid_o(resp_valid_o), .resp_hit_o(resp_hit_o),
    .resp_line_o(resp_line_o), .resp_dirty_o(resp_dirty_o),
    .wb_valid_o(wb_valid_o), .wb_blk_o(wb_blk_o), .wb_line_o(wb_line_o)
  );

  typedef struct {
    logic [TW-1:0] blk;
    logic [LW-1:0] line;
    bit            dirty;
  } ent_t;

  ent_t  mq[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string tag = "R1";

  bit            e_rv, e_hit, e_dirty, e_wb;
  logic [LW-1:0] e_line, e_wline;
  logic [TW-1:0] e_wblk;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(resp_valid_o === e_rv, "R3", "resp_valid", 64'(resp_valid_o), 64'(e_rv));
    if (e_rv) begin
      chk(resp_hit_o === e_hit, e_hit ? tag : "R3", "resp_hit", 64'(resp_hit_o), 64'(e_hit));
      chk(resp_line_o === e_line, e_hit ? tag : "R3", "resp_line", 64'(resp_line_o), 64'(e_line));
      if (e_hit)
        chk(resp_dirty_o === e_dirty, tag, "resp_dirty", 64'(resp_dirty_o), 64'(e_dirty));
    end
    chk(wb_valid_o === e_wb, e_wb ? "R8" : tag, "wb_valid", 64'(wb_valid_o), 64'(e_wb));
    if (e_wb) begin
      chk(wb_blk_o === e_wblk, "R8", "wb_blk", 64'(wb_blk_o), 64'(e_wblk));
      chk(wb_line_o === e_wline, "R8", "wb_line", 64'(wb_line_o), 64'(e_wline));
    end
  endtask

  function automatic int find(logic [TW-1:0] b);
    for (int i = 0; i < mq.size(); i++) if (mq[i].blk == b) return i;
    return -1;
  endfunction

  function automatic logic [TW-1:0] pick_fresh();
    logic [TW-1:0] c;
    for (int t = 0; t < 1000; t++) begin
      c = 22'h3F0000 | TW'($urandom_range(0, 11));
      if (find(c) < 0) return c;
    end
    return 22'h2AAAAA;
  endfunction

  task automatic step(bit lk, logic [TW-1:0] la,
                      bit sv, logic [TW-1:0] sa, logic [LW-1:0] sl, bit sd,
                      bit ev, logic [TW-1:0] ea, logic [LW-1:0] el, bit ed);
    int   idx;
    ent_t n, f;
    @(negedge clk);
    compare();
    lookup_valid_i = lk; lookup_blk_i = la;
    swap_valid_i = sv; swap_blk_i = sa; swap_line_i = sl; swap_dirty_i = sd;
    evict_valid_i = ev; evict_blk_i = ea; evict_line_i = el; evict_dirty_i = ed;
    e_rv = 0; e_hit = 0; e_line = '0; e_dirty = 0; e_wb = 0;
    if (!rst_ni) return;
    if (lk) begin
      e_rv = 1;
      idx = find(la);
      if (idx >= 0) begin
        e_hit = 1; e_line = mq[idx].line; e_dirty = mq[idx].dirty;
        mq.delete(idx);
        if (sv) begin
          n.blk = sa; n.line = sl; n.dirty = sd;
          mq.push_back(n);
        end
      end
    end else if (ev) begin
      if (mq.size() == N) begin
        f = mq.pop_front();
        if (f.dirty) begin
          e_wb = 1; e_wblk = f.blk; e_wline = f.line;
        end
      end
      n.blk = ea; n.line = el; n.dirty = ed;
      mq.push_back(n);
    end
  endtask

  task automatic idle();
    step(0, '0, 0, '0, '0, 0, 0, '0, '0, 0);
  endtask
  task automatic evict(logic [TW-1:0] a, logic [LW-1:0] l, bit d);
    step(0, '0, 0, '0, '0, 0, 1, a, l, d);
  endtask
  task automatic look(logic [TW-1:0] a);
    step(1, a, 0, '0, '0, 0, 0, '0, '0, 0);
  endtask
  task automatic look_swap(logic [TW-1:0] a, logic [TW-1:0] s, logic [LW-1:0] l, bit d);
    step(1, a, 1, s, l, d, 0, '0, '0, 0);
  endtask

  initial begin
    rst_ni = 0;
    evict_valid_i = 0; evict_blk_i = '0; evict_line_i = '0; evict_dirty_i = 0;
    lookup_valid_i = 0; lookup_blk_i = '0; swap_valid_i = 0; swap_blk_i = '0;
    swap_line_i = '0; swap_dirty_i = 0;
    e_rv = 0; e_hit = 0; e_line = '0; e_dirty = 0; e_wb = 0; e_wblk = '0; e_wline = '0;

    // R1: reset state and first lookup misses
    tag = "R1";
    repeat (3) idle();
    @(negedge clk);
    rst_ni = 1;
    idle();
    look(22'h000100);
    idle();

    // R6: filling free entries, no write-back
    tag = "R6";
    evict(22'h000100, 32'hA000_0000, 0);
    evict(22'h000101, 32'hA000_0001, 1);
    evict(22'h000102, 32'hA000_0002, 0);
    evict(22'h000103, 32'hA000_0003, 1);
    idle();

    // R2/R4: hit anywhere, swap in place
    tag = "R2";
    look_swap(22'h000102, 22'h000200, 32'hB000_0000, 1);
    tag = "R4";
    look(22'h000102);
    // R5: hit without swap frees the entry
    tag = "R5";
    look(22'h000200);
    look(22'h000200);
    idle();

    // R7/R8: replacement order and write-back
    tag = "R6";
    evict(22'h000300, 32'hC000_0000, 0);
    tag = "R7";
    evict(22'h000301, 32'hC000_0001, 0);
    evict(22'h000302, 32'hC000_0002, 1);
    look(22'h000100);
    look_swap(22'h000103, 22'h000303, 32'hC000_0003, 1);
    evict(22'h000304, 32'hC000_0004, 0);
    evict(22'h000305, 32'hC000_0005, 0);
    look(22'h000303);
    idle();

    // R9: eviction colliding with lookup is dropped
    tag = "R9";
    step(1, 22'h000999, 0, '0, '0, 0, 1, 22'h000400, 32'hD000_0000, 1);
    look(22'h000400);
    step(1, 22'h000305, 0, '0, '0, 0, 1, 22'h000401, 32'hD000_0001, 0);
    look(22'h000401);
    idle();

    // R7: randomized churn
    tag = "R7";
    for (int k = 0; k < 3000; k++) begin
      int r;
      logic [TW-1:0] a, s;
      r = $urandom_range(0, 9);
      if (mq.size() > 0 && $urandom_range(0, 1) == 1)
        a = mq[$urandom_range(0, mq.size() - 1)].blk;
      else
        a = 22'h3F0000 | TW'($urandom_range(0, 11));
      s = pick_fresh();
      if (r <= 3)
        step(1, a, r[0], s, $urandom, r[1], 0, '0, '0, 0);
      else if (r <= 6)
        step(0, '0, 0, '0, '0, 0, 1, s, $urandom, r[0]);
      else if (r == 7)
        step(1, a, 0, '0, '0, 0, 1, s, $urandom, 1);
      else
        idle();
    end
    idle();
    idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule